// File: doc/BRIEF.md
# Serial-Video Receiver Parallel Output Formatter

This block sits at the back end of a serial-video receiver. It takes the recovered 10-bit words, one for each word-clock enable, and lays them out on a 20-bit parallel bus with its own output strobe. In the wide layout each pair of incoming words is packed into one bus word: the luma sample goes on the upper half and the chroma sample on the lower half, so there is one output word for every two input words. In the narrow layout each input word appears on the upper half at the full word rate, and the lower half is held at zero. A pairing mark from the upstream timing-reference detector realigns the pairing, so that luma always lands on the upper half.

The operating mode comes from two mode signals: a video flag and an ASI flag. Video mode and data-through mode use the same layouts. ASI mode always uses the narrow layout. In slave mode the mode and rate signals come from outside the block. In master mode the block derives them from the lock flags of the upstream detectors and reports them. In master mode, when neither lock is present, the whole bus is blanked. A change of layout or mode takes effect only at a pairing boundary, and the first output word after the change is blanked, so a half-formed word never reaches the bus.

Top module: `vid_out_formatter`

## Requirements
- R1: Narrow layout. One cycle after an accepted input word w, dout_en pulses for exactly one cycle and dout = {w, 10'b0}. The lower half is zero.
- R2: Wide layout. The first word c of a pair produces no strobe. One cycle after the second word y, dout_en pulses once and dout = {y, c}: luma on bits [19:10], chroma on bits [9:0].
- R3: While the active mode is ASI, the narrow layout is used whatever wide_sel says.
- R4: Mode decode of (video, asi): (1,0) is video, (0,1) is ASI, (0,0) is data-through in slave mode only, and (1,1) is invalid. In the invalid mode, and in master mode with (0,0), every output word is zero.
- R5: Data-through mode passes words unchanged, in the same narrow and wide layouts as video mode.
- R6: Status reporting. In slave mode (master_en=0), st_sd, st_video and st_asi follow ctl_sd, ctl_video and ctl_asi, and st_drive = 0. In master mode st_drive = 1, st_video = trs_lock and st_asi = asi_lock & ~trs_lock. st_sd = 1 whenever st_asi = 1; otherwise st_sd = det_sd.
- R7: In master mode, when trs_lock and asi_lock are both low, dout reads zero from the next cycle onward, with or without word traffic.
- R8: A word accepted with trs_mark high becomes the first (chroma) word of a new pair. Any half-collected pair is dropped.
- R9: A change of layout or mode is applied only when a word starts a pair. The first output word formed under the new setting is all zero, and its strobe still pulses.
- R10: After reset, dout = 0 and dout_en = 0. The reset setting counts as a change, so the first output word after reset is blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | 1 = master (status driven by block), 0 = slave |
| wide_sel | input | 1 | 1 = wide (paired) layout, 0 = narrow |
| ctl_sd | input | 1 | Slave rate select, 1 = SD |
| ctl_video | input | 1 | Slave video-mode flag |
| ctl_asi | input | 1 | Slave ASI-mode flag |
| det_sd | input | 1 | Detected rate from upstream, 1 = SD |
| trs_lock | input | 1 | Timing references found in stream |
| asi_lock | input | 1 | ASI sync words found in stream |
| word_en | input | 1 | Input word valid this cycle |
| word_in | input | 10 | Recovered input word |
| trs_mark | input | 1 | With word_en: this word starts a pair |
| dout | output | 20 | Parallel output bus |
| dout_en | output | 1 | Output word strobe |
| st_sd | output | 1 | Reported rate, 1 = SD |
| st_video | output | 1 | Reported video-mode flag |
| st_asi | output | 1 | Reported ASI-mode flag |
| st_drive | output | 1 | 1 when the status outputs are driven by the block |

## Verification
Every output word is registered. A narrow word, or the second word of a pair, shows up with its strobe one clock after the word is accepted. The first word of a pair produces no strobe at all. The bench drives each word on a falling edge and samples at the following falling edge, which sits half a cycle after the register update. Loss of lock clears the bus at the first rising edge after the flags drop, and the bench checks this one full cycle after changing the flags. The status outputs are combinational and are checked a moment after their inputs change.

// File: rtl/vof_pkg.sv
package vof_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_VIDEO = 2'd1,
      MODE_ASI   = 2'd2,
      MODE_THRU  = 2'd3
   } vof_mode_e;

   typedef struct packed {
      vof_mode_e mode;
      logic      wide;
   } vof_cfg_t;

   // Map the two mode flags to an operating mode; pass-through needs slave
   function automatic vof_mode_e vof_decode(input logic video, input logic asi,
                                            input logic master);
      vof_mode_e m;
      case ({video, asi})
         2'b10:   m = MODE_VIDEO;
         2'b01:   m = MODE_ASI;
         2'b00:   m = master ? MODE_OFF : MODE_THRU;
         default: m = MODE_OFF;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/vof_mode_decode.sv
module vof_mode_decode
   import vof_pkg::*;
#(
   parameter bit ASI_FORCES_SD = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     master_en,
   input  logic     wide_sel,
   input  logic     ctl_sd,
   input  logic     ctl_video,
   input  logic     ctl_asi,
   input  logic     det_sd,
   input  logic     trs_lock,
   input  logic     asi_lock,
   output logic     st_sd,
   output logic     st_video,
   output logic     st_asi,
   output vof_cfg_t live_cfg,
   output logic     lock_lost
);

   logic m_video, m_asi, m_sd;

   assign m_video = trs_lock;
   assign m_asi   = asi_lock & ~trs_lock;

   generate
      if (ASI_FORCES_SD) begin : g_asi_sd
         assign m_sd = m_asi | det_sd;
      end else begin : g_det_sd
         assign m_sd = det_sd;
      end
   endgenerate

   always_comb begin
      if (master_en) begin
         st_sd    = m_sd;
         st_video = m_video;
         st_asi   = m_asi;
      end else begin
         st_sd    = ctl_sd;
         st_video = ctl_video;
         st_asi   = ctl_asi;
      end
      live_cfg.mode = vof_decode(st_video, st_asi, master_en);
      live_cfg.wide = wide_sel && (live_cfg.mode != MODE_ASI);
   end

   assign lock_lost = master_en & ~trs_lock & ~asi_lock;

   // R4: pass-through never decoded while the block is master
   a_r4_no_thru_master: assert property (@(posedge clk) disable iff (!rst_n)
      master_en |-> (live_cfg.mode != MODE_THRU));

   // R7: loss of both locks in master always decodes to the blank mode
   a_r7_lost_is_off: assert property (@(posedge clk) disable iff (!rst_n)
      lock_lost |-> (live_cfg.mode == MODE_OFF));

endmodule

// File: rtl/vof_pair_path.sv
module vof_pair_path
   import vof_pkg::*;
#(
   parameter int WORD_W     = 10,
   parameter bit LUMA_FIRST = 1'b0,
   localparam int OUT_W     = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_en,
   input  logic [WORD_W-1:0] word_in,
   input  logic              trs_mark,
   input  vof_cfg_t          live_cfg,
   input  logic              lock_lost,
   output logic [OUT_W-1:0]  dout,
   output logic              dout_en
);

   logic              pos_q;
   logic              pend_q;
   logic [WORD_W-1:0] hold_q;
   vof_cfg_t          act_q;
   logic [OUT_W-1:0]  dout_q;
   logic              en_q;

   logic              bnd, chg;
   vof_cfg_t          cfg_use;
   logic [OUT_W-1:0]  pair_word, narrow_word;

   assign bnd     = trs_mark || !pos_q;
   assign chg     = (live_cfg != act_q);
   assign cfg_use = (bnd && chg) ? live_cfg : act_q;

   generate
      if (LUMA_FIRST) begin : g_luma_first
         assign pair_word = {hold_q, word_in};
      end else begin : g_chroma_first
         assign pair_word = {word_in, hold_q};
      end
   endgenerate

   assign narrow_word = {word_in, {WORD_W{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q  <= 1'b0;
         pend_q <= 1'b0;
         hold_q <= '0;
         act_q  <= '{mode: MODE_OFF, wide: 1'b0};
         dout_q <= '0;
         en_q   <= 1'b0;
      end else begin
         en_q <= 1'b0;
         if (word_en) begin
            if (bnd) begin
               act_q <= cfg_use;
               if (cfg_use.wide) begin
                  hold_q <= word_in;
                  pos_q  <= 1'b1;
                  pend_q <= pend_q | chg;
               end else begin
                  pos_q  <= 1'b0;
                  pend_q <= 1'b0;
                  en_q   <= 1'b1;
                  dout_q <= (chg || cfg_use.mode == MODE_OFF) ? '0 : narrow_word;
               end
            end else begin
               pos_q  <= 1'b0;
               pend_q <= 1'b0;
               en_q   <= 1'b1;
               dout_q <= (pend_q || act_q.mode == MODE_OFF) ? '0 : pair_word;
            end
         end
         if (lock_lost) dout_q <= '0;
      end
   end

   assign dout    = dout_q;
   assign dout_en = en_q;

   // R1: a narrow word never carries data on the lower half
   a_r1_low_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !act_q.wide) |-> (dout_q[WORD_W-1:0] == '0));

   // R3: ASI never runs in the wide layout
   a_r3_asi_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q.mode == MODE_ASI) |-> !act_q.wide);

   // R7: bus cleared one cycle after both locks go away in master
   a_r7_blank_bus: assert property (@(posedge clk) disable iff (!rst_n)
      lock_lost |=> (dout_q == '0));

   // R2: every strobe answers an accepted word in the previous cycle
   a_r2_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> $past(word_en));

   // R9: a half-collected pair exists only under a wide setting
   a_r9_half_pair_wide: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q |-> act_q.wide);

   // R2: the first word of a pair gives no strobe
   a_r2_no_strobe_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pos_q) |-> !en_q);

endmodule

// File: rtl/vid_out_formatter.sv
module vid_out_formatter
   import vof_pkg::*;
#(
   parameter int WORD_W        = 10,
   parameter bit LUMA_FIRST    = 1'b0,
   parameter bit ASI_FORCES_SD = 1'b1,
   localparam int OUT_W        = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_en,
   input  logic              wide_sel,
   input  logic              ctl_sd,
   input  logic              ctl_video,
   input  logic              ctl_asi,
   input  logic              det_sd,
   input  logic              trs_lock,
   input  logic              asi_lock,
   input  logic              word_en,
   input  logic [WORD_W-1:0] word_in,
   input  logic              trs_mark,
   output logic [OUT_W-1:0]  dout,
   output logic              dout_en,
   output logic              st_sd,
   output logic              st_video,
   output logic              st_asi,
   output logic              st_drive
);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("vid_out_formatter: WORD_W must be at least 2");
      end
   endgenerate

   vof_cfg_t live_cfg;
   logic     lock_lost;

   vof_mode_decode #(
      .ASI_FORCES_SD (ASI_FORCES_SD)
   ) i_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .master_en (master_en),
      .wide_sel  (wide_sel),
      .ctl_sd    (ctl_sd),
      .ctl_video (ctl_video),
      .ctl_asi   (ctl_asi),
      .det_sd    (det_sd),
      .trs_lock  (trs_lock),
      .asi_lock  (asi_lock),
      .st_sd     (st_sd),
      .st_video  (st_video),
      .st_asi    (st_asi),
      .live_cfg  (live_cfg),
      .lock_lost (lock_lost)
   );

   vof_pair_path #(
      .WORD_W     (WORD_W),
      .LUMA_FIRST (LUMA_FIRST)
   ) i_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_en   (word_en),
      .word_in   (word_in),
      .trs_mark  (trs_mark),
      .live_cfg  (live_cfg),
      .lock_lost (lock_lost),
      .dout      (dout),
      .dout_en   (dout_en)
   );

   assign st_drive = master_en;

   // R6: in master mode the ASI and video reports are never both high
   a_r6_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      master_en |-> !(st_video && st_asi));

endmodule

// File: tb/test_vid_out_formatter.sv
module test_vid_out_formatter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master_en = 1'b0, wide_sel = 1'b0;
   logic        ctl_sd = 1'b1, ctl_video = 1'b1, ctl_asi = 1'b0;
   logic        det_sd = 1'b1, trs_lock = 1'b0, asi_lock = 1'b0;
   logic        word_en = 1'b0, trs_mark = 1'b0;
   logic [9:0]  word_in = '0;
   logic [19:0] dout;
   logic        dout_en, st_sd, st_video, st_asi, st_drive;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vid_out_formatter i_vid_out_formatter (
      .clk(clk), .rst_n(rst_n), .master_en(master_en), .wide_sel(wide_sel),
      .ctl_sd(ctl_sd), .ctl_video(ctl_video), .ctl_asi(ctl_asi),
      .det_sd(det_sd), .trs_lock(trs_lock), .asi_lock(asi_lock),
      .word_en(word_en), .word_in(word_in), .trs_mark(trs_mark),
      .dout(dout), .dout_en(dout_en), .st_sd(st_sd), .st_video(st_video),
      .st_asi(st_asi), .st_drive(st_drive)
   );

   task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one word on a falling edge; return at the next falling edge
   task automatic send(input logic [9:0] w, input logic mark);
      @(negedge clk);
      word_in  = w;
      trs_mark = mark;
      word_en  = 1'b1;
      @(negedge clk);
      word_en  = 1'b0;
      trs_mark = 1'b0;
   endtask

   task automatic out_chk(input string req, input logic en, input logic [19:0] d);
      chk({req, " strobe"}, {19'd0, dout_en}, {19'd0, en});
      if (en) chk({req, " data"}, dout, d);
   endtask

   task automatic stat_chk(input string req, input logic sd, input logic v,
                           input logic a, input logic drv);
      #1;
      chk(req, {16'd0, st_sd, st_video, st_asi, st_drive}, {16'd0, sd, v, a, drv});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [9:0] c, y, w;
      repeat (3) @(negedge clk);
      chk("R10 reset dout", dout, 20'd0);
      chk("R10 reset strobe", {19'd0, dout_en}, 20'd0);
      rst_n = 1'b1;

      // slave, video, narrow; first word after reset is blanked
      send(10'h155, 1'b0);
      out_chk("R10 first word blank", 1'b1, 20'd0);
      for (int i = 0; i < 64; i++) begin
         w = 10'((i * 37 + 11) % 1024);
         send(w, 1'b0);
         out_chk("R1 narrow", 1'b1, {w, 10'd0});
      end

      // switch to wide: first pair blanked (R9)
      wide_sel = 1'b1;
      send(10'h0AA, 1'b0);
      out_chk("R2 first of pair no strobe", 1'b0, 20'd0);
      send(10'h0BB, 1'b0);
      out_chk("R9 wide change blank", 1'b1, 20'd0);
      for (int i = 0; i < 48; i++) begin
         c = 10'((i * 91 + 3) % 1024);
         y = 10'((i * 53 + 700) % 1024);
         send(c, 1'b0);
         out_chk("R2 chroma slot", 1'b0, 20'd0);
         send(y, 1'b0);
         out_chk("R2 pair", 1'b1, {y, c});
      end

      // realign with trs_mark in the middle of a pair
      send(10'h3F0, 1'b0);
      out_chk("R8 half pair", 1'b0, 20'd0);
      send(10'h111, 1'b1);
      out_chk("R8 marked word starts pair", 1'b0, 20'd0);
      send(10'h222, 1'b0);
      out_chk("R8 realigned pair", 1'b1, {10'h222, 10'h111});

      // slave ASI with wide_sel still high: narrow forced
      ctl_video = 1'b0; ctl_asi = 1'b1;
      stat_chk("R6 slave echo asi", 1'b1, 1'b0, 1'b1, 1'b0);
      send(10'h0C3, 1'b0);
      out_chk("R9 asi change blank", 1'b1, 20'd0);
      for (int i = 0; i < 16; i++) begin
         w = 10'((i * 61 + 5) % 1024);
         send(w, 1'b0);
         out_chk("R3 asi narrow", 1'b1, {w, 10'd0});
      end

      // slave data-through, wide then narrow
      ctl_asi = 1'b0; ctl_sd = 1'b0;
      stat_chk("R6 slave echo thru", 1'b0, 1'b0, 1'b0, 1'b0);
      send(10'h001, 1'b0);
      out_chk("R5 thru first no strobe", 1'b0, 20'd0);
      send(10'h002, 1'b0);
      out_chk("R9 thru change blank", 1'b1, 20'd0);
      for (int i = 0; i < 16; i++) begin
         c = 10'((i * 29 + 400) % 1024);
         y = 10'((i * 17 + 9) % 1024);
         send(c, 1'b0);
         send(y, 1'b0);
         out_chk("R5 thru pair", 1'b1, {y, c});
      end
      wide_sel = 1'b0;
      send(10'h2A2, 1'b0);
      out_chk("R9 narrow change blank", 1'b1, 20'd0);
      send(10'h2A3, 1'b0);
      out_chk("R5 thru narrow", 1'b1, {10'h2A3, 10'd0});

      // slave invalid (1,1)
      ctl_video = 1'b1; ctl_asi = 1'b1;
      send(10'h3FF, 1'b0);
      out_chk("R4 invalid change", 1'b1, 20'd0);
      send(10'h3FF, 1'b0);
      out_chk("R4 invalid zero", 1'b1, 20'd0);

      // master status reporting
      master_en = 1'b1; det_sd = 1'b0; trs_lock = 1'b1; asi_lock = 1'b0;
      stat_chk("R6 master video", 1'b0, 1'b1, 1'b0, 1'b1);
      asi_lock = 1'b1;
      stat_chk("R6 master both locks", 1'b0, 1'b1, 1'b0, 1'b1);
      trs_lock = 1'b0;
      stat_chk("R6 master asi forces sd", 1'b1, 1'b0, 1'b1, 1'b1);
      trs_lock = 1'b1; asi_lock = 1'b0;

      send(10'h123, 1'b0);
      out_chk("R9 master change blank", 1'b1, 20'd0);
      send(10'h321, 1'b0);
      out_chk("R1 master narrow", 1'b1, {10'h321, 10'd0});

      // lose lock: bus zero one cycle later without traffic
      @(negedge clk);
      trs_lock = 1'b0;
      @(negedge clk);
      chk("R7 bus blank after lock loss", dout, 20'd0);
      chk("R7 no strobe without word", {19'd0, dout_en}, 20'd0);
      send(10'h155, 1'b0);
      out_chk("R4 master no-lock not thru", 1'b1, 20'd0);
      send(10'h2AA, 1'b0);
      out_chk("R7 master no-lock zero", 1'b1, 20'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule